// File: doc/BRIEF.md
# Display Controller Register Access Engine

This block is an SPI master that carries out single 16-bit register accesses on a small display controller. A host hands it one request at a time through a valid/ready port. A request holds an operation code, an 8-bit register index and a 16-bit write value. The engine turns the request into one or two serial frames. Each frame is bounded by an active-low chip select and opens with a protocol lead byte. That byte carries a device-identity bit, a register/index selector bit and a direction bit.

A register write or read sends an index frame, raises chip select for a guard time, and then sends a data frame. A status query is a single longer frame. Read results are collected from the incoming serial line. They are presented with a one-cycle completion pulse. A transmit-inversion option complements every outgoing byte for boards that invert the data line.

The serial clock is derived from the system clock. Register frames are held under a 4 MHz ceiling. The data frame of an access to the pixel-memory port index may run from a faster divider.

Top module: `disp_reg_spi`

## Requirements
- R1: Every frame opens with a lead byte sent MSB first as bits 0,1,1,1,0 followed by the latched `devId`, a selector bit (0 = index, 1 = data) and a direction bit in the LSB (0 = write, 1 = read).
- R2: Op code 0 (write) sends an index frame of three bytes {lead with selector 0 and direction 0, 0x00, index}. It then sends a data frame of three bytes {lead with selector 1 and direction 0, value[15:8], value[7:0]}.
- R3: Op code 1 (read) sends the same index frame as R2. It then sends a data frame {lead with selector 1 and direction 1, 0x00, 0x00}. `rspData` is the second received byte of that frame as the high half and the third as the low half.
- R4: Op codes 2 and 3 (status) send one four-byte frame {lead with selector 0 and direction 1, 0x00, 0x00, 0x00}. The second received byte is discarded. `rspData` is the third received byte (high) and the fourth (low).
- R5: With `invertTx` high at acceptance, every transmitted bit of every byte, fillers included, is complemented. Received data is not affected.
- R6: Between the index frame and the data frame, chip select stays high for exactly CS_GAP_SCLK × 2 × REG_HALF clock cycles. While chip select is high, SCLK and MOSI are low.
- R7: Each bit takes HALF cycles with SCLK low followed by HALF cycles with SCLK high (mode 0). MOSI changes only while SCLK is low. MISO is captured at the rising SCLK edge.
- R8: Index and status frames use REG_HALF = ceil(CLK_HZ / (2 × REG_MAX_HZ)), which is 16 by default. The data frame of an access whose index equals GRAM_IDX (0x22 by default) uses MEM_HALF, which is 2 by default.
- R9: `reqReady` is high only when idle, and a request is taken on a cycle with `reqValid` and `reqReady` both high. Chip select falls in the cycle after acceptance. `rspDone` is high for exactly one cycle, which immediately follows the last SCLK high half. In that cycle chip select is high and `rspData` holds the result, or zero after a write.
- R10: After reset, chip select is high, SCLK, MOSI and `rspDone` are low, and `reqReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devId | input | 1 | Device-identity bit placed in every lead byte |
| invertTx | input | 1 | Complement all transmitted bytes |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Engine idle and able to take a request |
| reqOp | input | 2 | 0 write, 1 read, 2 or 3 status |
| reqIndex | input | 8 | Register index |
| reqWdata | input | 16 | Value for a write |
| rspDone | output | 1 | One-cycle completion pulse |
| rspData | output | 16 | Read or status result, valid with rspDone |
| spiSclk | output | 1 | Serial clock, idle low |
| spiMosi | output | 1 | Serial data to the display |
| spiMiso | input | 1 | Serial data from the display |
| spiCsN | output | 1 | Active-low chip select |

## Verification
The assertions take for granted that the host raises `reqValid` only to start a new access and that the request fields hold during the accepting cycle. They also assume the display drives MISO so that it is settled before each rising SCLK. The bench keeps to this in three ways. It presents each request for a single cycle while the engine is idle. It holds `devId` and `invertTx` steady around acceptance. Its slave model moves MISO only on a falling SCLK or a falling chip select. It predicts every pin on every clock from the frame contents and from the half-period and guard counts.

// File: rtl/disp_reg_spi_pkg.sv
package disp_reg_spi_pkg;

  typedef enum logic [1:0] {
    PH_INDEX  = 2'd0,
    PH_WDATA  = 2'd1,
    PH_RDATA  = 2'd2,
    PH_STATUS = 2'd3
  } phase_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic   accept;
    logic   load;
    phase_e loadPhase;
    logic   shift;
    logic   sample;
    logic   capture;
    logic   captureRead;
  } strobe_t;

  function automatic logic [7:0] leadByte(input logic id, input logic sel, input logic dir);
    return {5'b01110, id, sel, dir};
  endfunction

endpackage

// File: rtl/disp_reg_spi_dp.sv
module disp_reg_spi_dp
  import disp_reg_spi_pkg::*;
#(
  parameter logic [7:0] GRAM_IDX = 8'h22
) (
  input  logic        clk,
  input  logic        rstN,
  input  strobe_t     stb,
  input  logic        devId,
  input  logic        invertTx,
  input  logic [7:0]  reqIndex,
  input  logic [15:0] reqWdata,
  input  logic        spiMiso,
  output logic        txBit,
  output logic        memFast,
  output logic [15:0] rdData
);

  logic [7:0]  latIndex;
  logic [15:0] latWdata;
  logic        latId;
  logic        latInv;
  logic [31:0] txShift;
  logic [15:0] rxShift;

  logic        srcId;
  logic        srcInv;
  logic [7:0]  srcIndex;
  logic [15:0] srcWdata;
  logic [31:0] rawFrame;
  logic [31:0] nextFrame;

  always_comb begin
    srcId    = stb.accept ? devId    : latId;
    srcInv   = stb.accept ? invertTx : latInv;
    srcIndex = stb.accept ? reqIndex : latIndex;
    srcWdata = stb.accept ? reqWdata : latWdata;
    case (stb.loadPhase)
      PH_INDEX:  rawFrame = {leadByte(srcId, 1'b0, 1'b0), 8'h00, srcIndex, 8'h00};
      PH_WDATA:  rawFrame = {leadByte(srcId, 1'b1, 1'b0), srcWdata, 8'h00};
      PH_RDATA:  rawFrame = {leadByte(srcId, 1'b1, 1'b1), 24'h000000};
      default:   rawFrame = {leadByte(srcId, 1'b0, 1'b1), 24'h000000};
    endcase
    nextFrame = srcInv ? ~rawFrame : rawFrame;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latIndex <= '0;
      latWdata <= '0;
      latId    <= 1'b0;
      latInv   <= 1'b0;
      txShift  <= '0;
      rxShift  <= '0;
      rdData   <= '0;
    end else begin
      if (stb.accept) begin
        latIndex <= reqIndex;
        latWdata <= reqWdata;
        latId    <= devId;
        latInv   <= invertTx;
      end
      if (stb.load) begin
        txShift <= nextFrame;
        rxShift <= '0;
      end else begin
        if (stb.shift)  txShift <= {txShift[30:0], 1'b0};
        if (stb.sample) rxShift <= {rxShift[14:0], spiMiso};
      end
      if (stb.capture) rdData <= stb.captureRead ? rxShift : 16'h0000;
    end
  end

  assign txBit   = txShift[31];
  assign memFast = (latIndex == GRAM_IDX);

endmodule

// File: rtl/disp_reg_spi_ctrl.sv
module disp_reg_spi_ctrl
  import disp_reg_spi_pkg::*;
#(
  parameter int REG_HALF = 16,
  parameter int MEM_HALF = 2,
  parameter int GAP_CYC  = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       memFast,
  output logic       reqReady,
  output strobe_t    stb,
  output logic       sclk,
  output logic       csN,
  output logic       done
);

  localparam int MAX_HALF = (REG_HALF > MEM_HALF) ? REG_HALF : MEM_HALF;
  localparam int HW = $clog2(MAX_HALF + 1);
  localparam int GW = $clog2(GAP_CYC + 1);
  localparam logic [HW-1:0] REG_LAST = HW'(REG_HALF - 1);
  localparam logic [HW-1:0] MEM_LAST = HW'(MEM_HALF - 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_GAP, S_DONE} state_e;

  state_e        state;
  phase_e        phase;
  logic          isWrite;
  logic [HW-1:0] halfCnt;
  logic [4:0]    bitCnt;
  logic [GW-1:0] gapCnt;

  logic [HW-1:0] curLast;
  logic          halfEnd;
  logic          lastBit;
  logic          dataPhase;
  phase_e        firstPhase;
  phase_e        secondPhase;

  always_comb begin
    dataPhase   = (phase == PH_WDATA) || (phase == PH_RDATA);
    curLast     = (dataPhase && memFast) ? MEM_LAST : REG_LAST;
    halfEnd     = (halfCnt == curLast);
    lastBit     = (bitCnt == ((phase == PH_STATUS) ? 5'd31 : 5'd23));
    firstPhase  = reqOp[1] ? PH_STATUS : PH_INDEX;
    secondPhase = isWrite ? PH_WDATA : PH_RDATA;
    reqReady    = (state == S_IDLE);

    stb = '0;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          stb.accept    = 1'b1;
          stb.load      = 1'b1;
          stb.loadPhase = firstPhase;
        end
      end
      S_SHIFT: begin
        if (halfEnd) begin
          if (!sclk) begin
            stb.sample = 1'b1;
          end else if (!lastBit) begin
            stb.shift = 1'b1;
          end else if (phase != PH_INDEX) begin
            stb.capture     = 1'b1;
            stb.captureRead = (phase != PH_WDATA);
          end
        end
      end
      S_GAP: begin
        if (gapCnt == GAP_LAST) begin
          stb.load      = 1'b1;
          stb.loadPhase = secondPhase;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      phase   <= PH_INDEX;
      isWrite <= 1'b0;
      halfCnt <= '0;
      bitCnt  <= '0;
      gapCnt  <= '0;
      sclk    <= 1'b0;
      csN     <= 1'b1;
      done    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (reqValid) begin
            isWrite <= (reqOp == 2'b00);
            phase   <= firstPhase;
            csN     <= 1'b0;
            halfCnt <= '0;
            bitCnt  <= '0;
            state   <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (halfEnd) begin
            halfCnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (!lastBit) begin
                bitCnt <= bitCnt + 5'd1;
              end else begin
                csN    <= 1'b1;
                bitCnt <= '0;
                if (phase == PH_INDEX) begin
                  gapCnt <= '0;
                  state  <= S_GAP;
                end else begin
                  done  <= 1'b1;
                  state <= S_DONE;
                end
              end
            end
          end else begin
            halfCnt <= halfCnt + 1'b1;
          end
        end
        S_GAP: begin
          if (gapCnt == GAP_LAST) begin
            csN     <= 1'b0;
            phase   <= secondPhase;
            halfCnt <= '0;
            state   <= S_SHIFT;
          end else begin
            gapCnt <= gapCnt + 1'b1;
          end
        end
        default: begin
          done  <= 1'b0;
          state <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/disp_reg_spi.sv
module disp_reg_spi
  import disp_reg_spi_pkg::*;
#(
  parameter int          CLK_HZ      = 125_000_000,
  parameter int          REG_MAX_HZ  = 4_000_000,
  parameter int          MEM_HALF    = 2,
  parameter int          CS_GAP_SCLK = 2,
  parameter logic [7:0]  GRAM_IDX    = 8'h22
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        devId,
  input  logic        invertTx,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqOp,
  input  logic [7:0]  reqIndex,
  input  logic [15:0] reqWdata,
  output logic        rspDone,
  output logic [15:0] rspData,
  output logic        spiSclk,
  output logic        spiMosi,
  input  logic        spiMiso,
  output logic        spiCsN
);

  localparam int REG_HALF_RAW = (CLK_HZ + 2 * REG_MAX_HZ - 1) / (2 * REG_MAX_HZ);
  localparam int REG_HALF     = (REG_HALF_RAW < 1) ? 1 : REG_HALF_RAW;
  localparam int GAP_CYC      = CS_GAP_SCLK * 2 * REG_HALF;

  strobe_t stb;
  logic    txBit;
  logic    memFast;

  disp_reg_spi_ctrl #(
    .REG_HALF (REG_HALF),
    .MEM_HALF (MEM_HALF),
    .GAP_CYC  (GAP_CYC)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqOp    (reqOp),
    .memFast  (memFast),
    .reqReady (reqReady),
    .stb      (stb),
    .sclk     (spiSclk),
    .csN      (spiCsN),
    .done     (rspDone)
  );

  disp_reg_spi_dp #(
    .GRAM_IDX (GRAM_IDX)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .devId    (devId),
    .invertTx (invertTx),
    .reqIndex (reqIndex),
    .reqWdata (reqWdata),
    .spiMiso  (spiMiso),
    .txBit    (txBit),
    .memFast  (memFast),
    .rdData   (rspData)
  );

  assign spiMosi = !spiCsN && txBit;

endmodule

// File: rtl/disp_reg_spi_chk.sv
module disp_reg_spi_chk #(
  parameter int GAP_CYC = 64
) (
  input logic clk,
  input logic rstN,
  input logic reqReady,
  input logic rspDone,
  input logic spiSclk,
  input logic spiMosi,
  input logic spiCsN
);

  int gapRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapRun <= 0;
    else if (spiCsN && !reqReady && !rspDone) gapRun <= gapRun + 1;
    else if (!spiCsN) gapRun <= 0;
  end

  assert_sclk_low_cs_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    spiCsN |-> (!spiSclk && !spiMosi));

  assert_guard_length_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && gapRun != 0) |-> (gapRun == GAP_CYC));

  assert_mosi_moves_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!spiCsN && !$stable(spiMosi)) |-> !spiSclk);

  assert_frame_starts_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(spiCsN) |-> !spiSclk);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  assert_done_deselected_R9: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (spiCsN && !reqReady));

  assert_ready_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (spiCsN && !rspDone));

endmodule

bind disp_reg_spi disp_reg_spi_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqReady (reqReady),
  .rspDone  (rspDone),
  .spiSclk  (spiSclk),
  .spiMosi  (spiMosi),
  .spiCsN   (spiCsN)
);

// File: tb/disp_reg_spi_tb.sv
module disp_reg_spi_tb;

  localparam int RH = 16;          // 125 MHz / (2 * 4 MHz), rounded up
  localparam int MH = 2;
  localparam int G  = 2 * 2 * RH;  // two register-rate SCLK periods

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN = 1'b0;
  logic        devId = 1'b0;
  logic        invertTx = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'b00;
  logic [7:0]  reqIndex = 8'h00;
  logic [15:0] reqWdata = 16'h0000;
  logic        rspDone;
  logic [15:0] rspData;
  logic        spiSclk;
  logic        spiMosi;
  logic        spiMiso;
  logic        spiCsN;

  disp_reg_spi u_dut (
    .clk(clk), .rstN(rstN), .devId(devId), .invertTx(invertTx),
    .reqValid(reqValid), .reqReady(reqReady), .reqOp(reqOp),
    .reqIndex(reqIndex), .reqWdata(reqWdata), .rspDone(rspDone),
    .rspData(rspData), .spiSclk(spiSclk), .spiMosi(spiMosi),
    .spiMiso(spiMiso), .spiCsN(spiCsN)
  );

  // expected per cycle: {ready, csN, sclk, mosi, done}
  bit [4:0]    expQ[$];
  string       tagQ[$];
  logic [15:0] rdQ[$];
  logic [31:0] slaveQ[$];
  logic [31:0] slaveBits = '0;
  int          sIdx = 0;
  int          nChecks = 0;
  int          nFails = 0;
  bit          running = 1'b0;
  bit          finished = 1'b0;

  // display model: shifts on falling SCLK, first bit ready at chip-select fall
  always @(negedge spiCsN) begin
    slaveBits = (slaveQ.size() > 0) ? slaveQ.pop_front() : 32'h0;
    sIdx = 0;
  end
  always @(negedge spiSclk) if (!spiCsN && sIdx < 31) sIdx = sIdx + 1;
  assign spiMiso = spiCsN ? 1'b0 : slaveBits[31 - sIdx];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finishUp();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    bit [4:0]    e;
    string       t;
    logic [15:0] r;
    if (running) begin
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        t = tagQ.pop_front();
      end else begin
        e = 5'b11000;
        t = "R9/R10 idle";
      end
      chk({reqReady, spiCsN, spiSclk, spiMosi, rspDone} == e, t,
          "pins{rdy,cs,sclk,mosi,done}",
          {27'd0, reqReady, spiCsN, spiSclk, spiMosi, rspDone}, {27'd0, e});
      if (e[0]) begin
        r = rdQ.pop_front();
        chk(rspData == r, t, "rspData", {16'd0, rspData}, {16'd0, r});
      end
    end
  end

  function automatic logic [7:0] lead(input logic id, input logic sel, input logic dir);
    return 8'h70 | (8'(id) << 2) | (8'(sel) << 1) | 8'(dir);
  endfunction

  task automatic pushFrame(input logic [31:0] bits, input int nBytes, input int half,
                           input string tag);
    for (int i = 0; i < nBytes * 8; i++) begin
      for (int k = 0; k < 2 * half; k++) begin
        expQ.push_back({1'b0, 1'b0, (k >= half), bits[31 - i], 1'b0});
        tagQ.push_back(tag);
      end
    end
  endtask

  task automatic pushCsHigh(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(5'b01000);
      tagQ.push_back(tag);
    end
  endtask

  // op: 0 write, 1 read, 2/3 status; resp = value the display returns
  task automatic access(input logic [1:0] op, input logic [7:0] idx, input logic [15:0] wval,
                        input logic id, input logic inv, input logic [15:0] resp,
                        input string tag);
    logic [31:0] fA;
    logic [31:0] fB;
    int          dh;
    dh = (idx == 8'h22) ? MH : RH;
    if (op[1]) begin
      slaveQ.push_back({8'h00, 8'hC3, resp});          // second byte is junk
    end else begin
      slaveQ.push_back(32'h0);
      slaveQ.push_back({8'h5A, resp, 8'h00});          // first byte ignored
    end
    @(negedge clk);
    reqOp = op; reqIndex = idx; reqWdata = wval; devId = id; invertTx = inv;
    reqValid = 1'b1;
    @(posedge clk);
    if (op[1]) begin
      fA = {lead(id, 1'b0, 1'b1), 24'h0};
      if (inv) fA = ~fA;
      pushFrame(fA, 4, RH, tag);
      expQ.push_back(5'b01001); tagQ.push_back(tag); rdQ.push_back(resp);
    end else begin
      fA = {lead(id, 1'b0, 1'b0), 8'h00, idx, 8'h00};
      fB = (op == 2'b00) ? {lead(id, 1'b1, 1'b0), wval, 8'h00}
                         : {lead(id, 1'b1, 1'b1), 24'h0};
      if (inv) begin fA = ~fA; fB = ~fB; end
      pushFrame(fA, 3, RH, tag);
      pushCsHigh(G, tag);
      pushFrame(fB, 3, dh, tag);
      expQ.push_back(5'b01001); tagQ.push_back(tag);
      rdQ.push_back((op == 2'b00) ? 16'h0000 : resp);
    end
    @(negedge clk);
    reqValid = 1'b0;
    wait (expQ.size() == 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL R9 watchdog actual=hung expected=complete");
    finishUp();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: state held in reset
    chk({reqReady, spiCsN, spiSclk, spiMosi, rspDone} == 5'b11000, "R10", "reset pins",
        {27'd0, reqReady, spiCsN, spiSclk, spiMosi, rspDone}, 32'h18);
    rstN = 1'b1;
    running = 1'b1;
    repeat (2) @(negedge clk);

    access(2'd0, 8'h10, 16'h4240, 1'b1, 1'b0, 16'h0000, "R1/R2/R6/R7 write id1");
    access(2'd0, 8'h13, 16'h1319, 1'b0, 1'b0, 16'h0000, "R1/R2/R6/R7 write id0");
    access(2'd1, 8'h00, 16'hFFFF, 1'b1, 1'b0, 16'h9221, "R3/R7 read");
    access(2'd2, 8'h00, 16'h0000, 1'b1, 1'b0, 16'h1234, "R4 status op2");
    access(2'd3, 8'h55, 16'hAAAA, 1'b0, 1'b0, 16'hBEEF, "R4 status op3");
    access(2'd0, 8'h30, 16'h0302, 1'b1, 1'b1, 16'h0000, "R5 inverted write");
    access(2'd1, 8'h07, 16'h0000, 1'b1, 1'b1, 16'hA50F, "R5 inverted read");
    access(2'd2, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h8001, "R5 inverted status");
    access(2'd0, 8'h22, 16'hF81F, 1'b1, 1'b0, 16'h0000, "R8 fast data write");
    access(2'd1, 8'h22, 16'h0000, 1'b1, 1'b0, 16'h07E0, "R8 fast data read");
    access(2'd1, 8'h21, 16'h0000, 1'b1, 1'b0, 16'hFFFF, "R8/R3 slow read all ones");
    access(2'd0, 8'hFF, 16'h0000, 1'b1, 1'b0, 16'h0000, "R2/R9 back to back");
    access(2'd1, 8'hFF, 16'h0000, 1'b0, 1'b0, 16'h0000, "R3/R9 read zero");

    repeat (5) @(negedge clk);
    finishUp();
  end

endmodule